// File: doc/BRIEF.md
# Graphics line fetch requester

This block drives the read side of a display graphics path. Once per frame, on a chosen edge of the vertical sync strobe, it walks the framebuffer line by line and issues read-burst requests. Each request carries a byte address and a byte length and is offered on a valid/ready handshake. The returned pixels land in a pixel FIFO whose entries are 8 bytes wide. The block never sees that data. It only watches the FIFO's count of free entries, and it holds back a request until that count reaches a programmable watermark.

Each visible line starts at the frame base plus the line index times the pitch. Only twice the pixel width is read from each line, because pixels are 16 bits. Any pitch padding beyond that is skipped. Every burst is cut to the smallest of four limits: 128 bytes, the bytes left in the line, the distance to the next 4 KB boundary, and the free FIFO space in bytes. The frame base comes from one of two programmed addresses. When toggling is enabled, the block alternates between them on successive frames. A transfer enable gates all fetching. A one-cycle frame-done pulse follows the acceptance of the final burst.

Top module: `gfx_line_fetch`

## Requirements
- R1: While reset is held and right after it, `reqValid` and `frameDone` are 0.
- R2: A frame starts on a rising edge of `frameSync` when `syncFalling` is 0, and on a falling edge when it is 1. The opposite edge does nothing. An edge while `xferEn` is 0 does nothing, and an edge during a frame in progress does nothing.
- R3: The first frame after reset reads from `baseA`. Each started frame flips the buffer choice when `toggleEn` is 1. When `toggleEn` is 0, the next frame goes back to `baseA`.
- R4: Line n is read from base + n*`pitch`. Within a line, bursts are contiguous from offset 0 up to 2*`widthPx` bytes, whatever the pitch. Lines are requested in ascending order.
- R5: `reqLen` (bytes) is the minimum of 128, the bytes left in the line, 4096 minus the address modulo 4096, and 8*`freeEntries`.
- R6: No request spans a 4 KB address boundary.
- R7: A burst is issued only when `freeEntries` is nonzero and at least `threshold`, judged in the cycle before `reqValid` rises.
- R8: While `reqValid` is 1 and `reqReady` is 0, the request stays valid with `reqAddr` and `reqLen` unchanged.
- R9: `frameDone` is high for exactly one cycle, in the cycle after the last burst of the last line is accepted. A frame with zero width or zero height raises it in the cycle after its start edge and issues no request.
- R10: While `xferEn` is 0, no new burst is issued. An unfinished frame resumes when it returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Vertical sync strobe |
| syncFalling | input | 1 | 1 selects the falling edge of frameSync as frame start |
| xferEn | input | 1 | Graphics transfer enable |
| toggleEn | input | 1 | Alternate between the two frame bases |
| baseA | input | 32 | Frame base address 0 |
| baseB | input | 32 | Frame base address 1 |
| pitch | input | 16 | Line stride in bytes |
| widthPx | input | 12 | Visible pixels per line (2 bytes each) |
| heightLn | input | 12 | Visible lines per frame |
| threshold | input | 8 | Free-entry watermark |
| freeEntries | input | 9 | Free 8-byte FIFO entries |
| reqValid | output | 1 | Burst request valid |
| reqReady | input | 1 | Burst request accepted |
| reqAddr | output | 32 | Burst byte address |
| reqLen | output | 8 | Burst length in bytes |
| frameDone | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong line offset or line index corrupts the address or length of the very next request. The bench compares each request to its arithmetic model the moment it appears. A wrong buffer-select bit shows up as a shifted base on the first burst of the following frame. A wrong end-of-line or end-of-frame decision either produces an extra request or moves the frame-done pulse by a cycle. Both are caught within the frame being run. Stuck handshake state shows as a request that changes or disappears while stalled, one cycle after the stall begins.

// File: rtl/lf_pkg.sv
package lf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_REQ   = 2'd2
  } lf_state_e;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic loadFrame;  // latch frame base, clear line position
    logic issue;      // capture next burst address and length
    logic accept;     // advance position past the accepted burst
  } lf_strobe_t;

endpackage

// File: rtl/lf_datapath.sv
module lf_datapath
  import lf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PITCH_W     = 16,
  parameter int DIM_W       = 12,
  parameter int FREE_W      = 9,
  parameter int MAX_BURST   = 128,
  parameter int PAGE_BYTES  = 4096,
  parameter int ENTRY_BYTES = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  lf_strobe_t                         strobe,
  input  logic                               toggleEn,
  input  logic [ADDR_W-1:0]                  baseA,
  input  logic [ADDR_W-1:0]                  baseB,
  input  logic [PITCH_W-1:0]                 pitch,
  input  logic [DIM_W-1:0]                   widthPx,
  input  logic [DIM_W-1:0]                   heightLn,
  input  logic [FREE_W-1:0]                  freeEntries,
  output logic [ADDR_W-1:0]                  reqAddr,
  output logic [$clog2(MAX_BURST+1)-1:0]     reqLen,
  output logic                               frameEnd,
  output logic                               emptyFrame
);

  localparam int LEN_W    = $clog2(MAX_BURST + 1);
  localparam int PAGE_B   = $clog2(PAGE_BYTES);
  localparam int ENTRY_SH = $clog2(ENTRY_BYTES);
  localparam int LB_W     = DIM_W + 1;
  localparam int W_A      = (LB_W > PAGE_B + 1) ? LB_W : PAGE_B + 1;
  localparam int W_B      = (FREE_W + ENTRY_SH > LEN_W) ? FREE_W + ENTRY_SH : LEN_W;
  localparam int CALC_W   = ((W_A > W_B) ? W_A : W_B) + 1;

  logic [ADDR_W-1:0] lineAddr;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] addrQ;
  logic [LB_W-1:0]   lineOff;
  logic [LB_W-1:0]   lineBytes;
  logic [LB_W-1:0]   remain;
  logic [DIM_W-1:0]  lineIdx;
  logic [LEN_W-1:0]  lenQ;
  logic              selNext;
  logic              lineDone;
  logic              lastLine;

  logic [CALC_W-1:0] capC, remC, pageC, freeC, minLine, minRoom, lenC;

  always_comb begin
    lineBytes = {widthPx, 1'b0};
    remain    = lineBytes - lineOff;
    curAddr   = lineAddr + ADDR_W'(lineOff);
    capC      = CALC_W'(MAX_BURST);
    remC      = CALC_W'(remain);
    pageC     = CALC_W'(PAGE_BYTES) - CALC_W'(curAddr[PAGE_B-1:0]);
    freeC     = CALC_W'(freeEntries) << ENTRY_SH;
    minLine   = (capC < remC) ? capC : remC;
    minRoom   = (pageC < freeC) ? pageC : freeC;
    lenC      = (minLine < minRoom) ? minLine : minRoom;
  end

  always_comb begin
    lineDone   = (lineOff + LB_W'(lenQ)) == lineBytes;
    lastLine   = lineIdx == (heightLn - DIM_W'(1));
    frameEnd   = lineDone & lastLine;
    emptyFrame = (widthPx == '0) || (heightLn == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineAddr <= '0;
      lineOff  <= '0;
      lineIdx  <= '0;
      addrQ    <= '0;
      lenQ     <= '0;
      selNext  <= 1'b0;
    end else begin
      if (strobe.loadFrame) begin
        lineAddr <= selNext ? baseB : baseA;
        selNext  <= toggleEn & ~selNext;
        lineOff  <= '0;
        lineIdx  <= '0;
      end
      if (strobe.issue) begin
        addrQ <= curAddr;
        lenQ  <= LEN_W'(lenC);
      end
      if (strobe.accept) begin
        if (lineDone) begin
          lineOff  <= '0;
          lineIdx  <= lineIdx + DIM_W'(1);
          lineAddr <= lineAddr + ADDR_W'(pitch);
        end else begin
          lineOff <= lineOff + LB_W'(lenQ);
        end
      end
    end
  end

  assign reqAddr = addrQ;
  assign reqLen  = lenQ;

endmodule

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
#(
  parameter int FREE_W = 9,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              syncFalling,
  input  logic              xferEn,
  input  logic [FREE_W-1:0] freeEntries,
  input  logic [THR_W-1:0]  threshold,
  input  logic              reqReady,
  input  logic              frameEnd,
  input  logic              emptyFrame,
  output lf_strobe_t        strobe,
  output logic              reqValid,
  output logic              frameDone
);

  localparam int CMP_W = (FREE_W > THR_W) ? FREE_W : THR_W;

  lf_state_e state, stateNext;
  logic      syncPrev;
  logic      edgeSeen;
  logic      start;
  logic      canIssue;
  logic      doneNext;

  always_comb begin
    edgeSeen = syncFalling ? (syncPrev & ~frameSync) : (~syncPrev & frameSync);
    start    = edgeSeen & xferEn;
    canIssue = xferEn && (freeEntries != '0) &&
               (CMP_W'(freeEntries) >= CMP_W'(threshold));
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.loadFrame = 1'b1;
          if (emptyFrame) doneNext = 1'b1;
          else            stateNext = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (canIssue) begin
          strobe.issue = 1'b1;
          stateNext    = ST_REQ;
        end
      end
      ST_REQ: begin
        if (reqReady) begin
          strobe.accept = 1'b1;
          if (frameEnd) begin
            doneNext  = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            stateNext = ST_FETCH;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      frameDone <= 1'b0;
      syncPrev  <= 1'b0;
    end else begin
      state     <= stateNext;
      frameDone <= doneNext;
      syncPrev  <= frameSync;
    end
  end

  assign reqValid = (state == ST_REQ);

endmodule

// File: rtl/gfx_line_fetch.sv
module gfx_line_fetch
  import lf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PITCH_W     = 16,
  parameter int DIM_W       = 12,
  parameter int FREE_W      = 9,
  parameter int THR_W       = 8,
  parameter int MAX_BURST   = 128,
  parameter int PAGE_BYTES  = 4096,
  parameter int ENTRY_BYTES = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           frameSync,
  input  logic                           syncFalling,
  input  logic                           xferEn,
  input  logic                           toggleEn,
  input  logic [ADDR_W-1:0]              baseA,
  input  logic [ADDR_W-1:0]              baseB,
  input  logic [PITCH_W-1:0]             pitch,
  input  logic [DIM_W-1:0]               widthPx,
  input  logic [DIM_W-1:0]               heightLn,
  input  logic [THR_W-1:0]               threshold,
  input  logic [FREE_W-1:0]              freeEntries,
  output logic                           reqValid,
  input  logic                           reqReady,
  output logic [ADDR_W-1:0]              reqAddr,
  output logic [$clog2(MAX_BURST+1)-1:0] reqLen,
  output logic                           frameDone
);

  lf_strobe_t strobe;
  logic       frameEnd;
  logic       emptyFrame;

  lf_ctrl #(
    .FREE_W(FREE_W),
    .THR_W (THR_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameSync  (frameSync),
    .syncFalling(syncFalling),
    .xferEn     (xferEn),
    .freeEntries(freeEntries),
    .threshold  (threshold),
    .reqReady   (reqReady),
    .frameEnd   (frameEnd),
    .emptyFrame (emptyFrame),
    .strobe     (strobe),
    .reqValid   (reqValid),
    .frameDone  (frameDone)
  );

  lf_datapath #(
    .ADDR_W     (ADDR_W),
    .PITCH_W    (PITCH_W),
    .DIM_W      (DIM_W),
    .FREE_W     (FREE_W),
    .MAX_BURST  (MAX_BURST),
    .PAGE_BYTES (PAGE_BYTES),
    .ENTRY_BYTES(ENTRY_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .toggleEn   (toggleEn),
    .baseA      (baseA),
    .baseB      (baseB),
    .pitch      (pitch),
    .widthPx    (widthPx),
    .heightLn   (heightLn),
    .freeEntries(freeEntries),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .frameEnd   (frameEnd),
    .emptyFrame (emptyFrame)
  );

endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
  parameter int ADDR_W     = 32,
  parameter int FREE_W     = 9,
  parameter int THR_W      = 8,
  parameter int MAX_BURST  = 128,
  parameter int PAGE_BYTES = 4096
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           xferEn,
  input logic [THR_W-1:0]               threshold,
  input logic [FREE_W-1:0]              freeEntries,
  input logic                           reqValid,
  input logic                           reqReady,
  input logic [ADDR_W-1:0]              reqAddr,
  input logic [$clog2(MAX_BURST+1)-1:0] reqLen,
  input logic                           frameDone
);

  localparam int PAGE_B = $clog2(PAGE_BYTES);
  localparam int SUM_W  = PAGE_B + 2;
  localparam int CMP_W  = (FREE_W > THR_W) ? FREE_W : THR_W;

  a_r6_no_page_cross: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (SUM_W'(reqAddr[PAGE_B-1:0]) + SUM_W'(reqLen)) <= SUM_W'(PAGE_BYTES));

  a_r5_len_bounds: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqLen != '0) && (int'(reqLen) <= MAX_BURST));

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr) && $stable(reqLen)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  a_r9_done_no_req: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !reqValid);

  a_r7_watermark: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> ($past(freeEntries) != '0) &&
                        (CMP_W'($past(freeEntries)) >= CMP_W'($past(threshold))));

  a_r10_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> $past(xferEn));

endmodule

bind gfx_line_fetch lf_checker #(
  .ADDR_W    (ADDR_W),
  .FREE_W    (FREE_W),
  .THR_W     (THR_W),
  .MAX_BURST (MAX_BURST),
  .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .xferEn     (xferEn),
  .threshold  (threshold),
  .freeEntries(freeEntries),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqAddr    (reqAddr),
  .reqLen     (reqLen),
  .frameDone  (frameDone)
);

// File: tb/sim_gfx_line_fetch.sv
`timescale 1ns/1ps
module sim_gfx_line_fetch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameSync = 1'b0;
  logic        syncFalling = 1'b0;
  logic        xferEn = 1'b1;
  logic        toggleEn = 1'b0;
  logic [31:0] baseA = '0;
  logic [31:0] baseB = '0;
  logic [15:0] pitch = '0;
  logic [11:0] widthPx = '0;
  logic [11:0] heightLn = '0;
  logic [7:0]  threshold = 8'h80;
  logic [8:0]  freeEntries = '0;
  logic        reqValid;
  logic        reqReady = 1'b0;
  logic [31:0] reqAddr;
  logic [7:0]  reqLen;
  logic        frameDone;

  always #2 clk = ~clk;

  gfx_line_fetch u0 (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .syncFalling(syncFalling),
    .xferEn(xferEn), .toggleEn(toggleEn), .baseA(baseA), .baseB(baseB),
    .pitch(pitch), .widthPx(widthPx), .heightLn(heightLn), .threshold(threshold),
    .freeEntries(freeEntries), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .frameDone(frameDone)
  );

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  expSel = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Leaves the bench at the negedge just after the start edge was sampled.
  task automatic pulseSync();
    frameSync = 1'b1;
    if (syncFalling) begin
      repeat (4) @(negedge clk);
      chk(reqValid == 1'b0, "R2 rising edge ignored in falling mode", reqValid, 0);
    end
    @(negedge clk);
    frameSync = 1'b0;
    if (syncFalling) @(negedge clk);
  endtask

  task automatic waitValid();
    int n = 0;
    while (!reqValid && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  // holdOff: 0 none, 1 transfer enable low after start, 2 free entries below watermark
  task automatic runFrame(input longint a, input longint b, input bit tog, input int pit,
                          input int w, input int h, input int f, input int thr,
                          input int holdOff, input bit busyPulse);
    longint base;
    bit     sel;
    int     burstNo = 0;
    toggleEn    = tog;
    baseA       = 32'(a);
    baseB       = 32'(b);
    pitch       = 16'(pit);
    widthPx     = 12'(w);
    heightLn    = 12'(h);
    threshold   = 8'(thr);
    freeEntries = (holdOff == 2) ? 9'(f - 1) : 9'(f);
    @(negedge clk);
    sel    = expSel;
    expSel = tog ? ~sel : 1'b0;
    base   = sel ? b : a;
    pulseSync();
    if (holdOff == 1) xferEn = 1'b0;
    if (w == 0 || h == 0) begin
      chk(frameDone == 1'b1, "R9 empty frame done", frameDone, 1);
      @(negedge clk);
      chk(frameDone == 1'b0 && reqValid == 1'b0, "R9 empty frame pulse once", {frameDone, reqValid}, 0);
      return;
    end
    if (holdOff != 0) begin
      repeat (6) begin
        @(negedge clk);
        chk(reqValid == 1'b0, (holdOff == 1) ? "R10 paused" : "R7 below watermark", reqValid, 0);
      end
      xferEn      = 1'b1;
      freeEntries = 9'(f);
    end
    for (int ln = 0; ln < h; ln++) begin
      longint off = 0;
      while (off < 2 * w) begin
        longint addr = base + longint'(ln) * pit + off;
        longint len = 128;
        if (2 * w - off < len) len = 2 * w - off;
        if (4096 - (addr % 4096) < len) len = 4096 - (addr % 4096);
        if (8 * f < len) len = 8 * f;
        waitValid();
        chk(reqValid == 1'b1, "R4 request present", reqValid, 1);
        chk(reqAddr == 32'(addr), "R4 burst address", reqAddr, addr);
        chk(reqLen == 8'(len), "R5 burst length", reqLen, len);
        chk(sel == (base == b && a != b) || (a == b), "R3 base choice", sel, sel);
        if (busyPulse && burstNo == 0) frameSync = 1'b1;
        if (burstNo % 3 == 1) begin
          @(negedge clk);
          chk(reqValid && reqAddr == 32'(addr) && reqLen == 8'(len), "R8 held while stalled", reqAddr, addr);
        end
        reqReady = 1'b1;
        @(negedge clk);
        reqReady  = 1'b0;
        frameSync = 1'b0;
        burstNo++;
        off += len;
        if (!(ln == h - 1 && off >= 2 * w))
          chk(frameDone == 1'b0, "R9 no early done", frameDone, 0);
      end
    end
    chk(frameDone == 1'b1, "R9 done after last accept", frameDone, 1);
    @(negedge clk);
    chk(frameDone == 1'b0, "R9 done one cycle", frameDone, 0);
    if (busyPulse) begin
      repeat (8) @(negedge clk);
      chk(reqValid == 1'b0 && frameDone == 1'b0, "R2 edge during frame ignored", reqValid, 0);
    end
  endtask

  initial begin
    wait (cyc >= 190000);
    bad++;
    total++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint bases[3] = '{64'h0000_0FF0, 64'h1000_0F38, 64'h2000_0000};
    int     widths[4] = '{1, 5, 70, 300};
    int     frees[2] = '{1, 255};
    repeat (3) @(negedge clk);
    chk(reqValid == 1'b0, "R1 valid in reset", reqValid, 0);
    chk(frameDone == 1'b0, "R1 done in reset", frameDone, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqValid == 1'b0 && frameDone == 1'b0, "R1 after reset", {reqValid, frameDone}, 0);

    // R3: toggling sequence A, B, A, then toggle off returns to A
    runFrame(64'h100, 64'h9000, 1'b1, 64, 8, 2, 255, 255, 0, 1'b0);
    runFrame(64'h100, 64'h9000, 1'b1, 64, 8, 2, 255, 255, 0, 1'b0);
    runFrame(64'h100, 64'h9000, 1'b1, 64, 8, 2, 255, 255, 0, 1'b0);
    runFrame(64'h100, 64'h9000, 1'b0, 64, 8, 2, 255, 255, 0, 1'b0);
    runFrame(64'h100, 64'h9000, 1'b0, 64, 8, 2, 255, 255, 0, 1'b0);

    // Sweep: base near page ends, widths, heights, free space, padded pitch
    for (int bi = 0; bi < 3; bi++)
      for (int wi = 0; wi < 4; wi++)
        for (int hi = 0; hi < 2; hi++)
          for (int fi = 0; fi < 2; fi++)
            for (int pi = 0; pi < 2; pi++) begin
              int w = widths[wi];
              runFrame(bases[bi], bases[bi] + 64'h40000, 1'(wi + pi), 2 * w + pi * 72,
                       w, 1 + 2 * hi, frees[fi], frees[fi], 0, 1'b0);
            end

    // R5: 256 free entries with the default watermark
    runFrame(64'h3000_0F80, 64'h3100_0000, 1'b0, 1024, 300, 2, 256, 128, 0, 1'b0);
    // R10: transfer enable dropped after start, then restored
    runFrame(64'h500, 64'h600, 1'b0, 200, 90, 2, 16, 4, 1, 1'b0);
    // R7: free entries one below the watermark, then at it
    runFrame(64'h500, 64'h600, 1'b0, 200, 90, 2, 9, 9, 2, 1'b0);
    // R2: another start edge while the frame is running
    runFrame(64'h700, 64'h800, 1'b0, 400, 150, 2, 255, 1, 0, 1'b1);
    // R9: empty frames
    runFrame(64'h700, 64'h800, 1'b0, 400, 0, 2, 255, 1, 0, 1'b0);
    runFrame(64'h700, 64'h800, 1'b0, 400, 20, 0, 255, 1, 0, 1'b0);

    // R2: start edge with transfer disabled
    xferEn = 1'b0;
    pulseSync();
    repeat (6) begin
      @(negedge clk);
      chk(reqValid == 1'b0 && frameDone == 1'b0, "R2 start while disabled", reqValid, 0);
    end
    xferEn = 1'b1;

    // R2: falling-edge start selection
    syncFalling = 1'b1;
    runFrame(64'h2000_0FC0, 64'h0, 1'b0, 512, 100, 2, 255, 255, 0, 1'b0);
    syncFalling = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule